// File: doc/BRIEF.md
# Register Interlock Stall Scoreboard

This block sits beside the issue stage of a single-issue pipeline. For every architectural register it keeps a countdown of how many cycles remain before a pending result may be consumed. For each class of shared execution unit it keeps a busy window. The instruction waiting to issue presents three things:
- up to three source operands, each with its own timing requirement;
- a destination with its unavailability latency;
- an optional shared-unit claim with a hold time.

The block raises `stall` until every constraint is met. The instruction is accepted on a clock edge where `issue_valid` is high and `stall` is low. Only accepted instructions change the tracked state.

Latencies are counted from the issue cycle, which is taken as the producing instruction's last cycle. A destination latency of 0 means the result can be used by an instruction that starts on the next cycle. Each register counter is loaded with the latency plus a fixed bias equal to the largest early demand. Because of this bias, a single compare per operand covers early, on-time and late operand demands. A producer can mark its result as a multiply result. A source marked as an accumulator input then needs one cycle less.

Top module: `interlock_scoreboard`

## Requirements
- R1: A source with mode 2'b00 (needed on the consumer's first cycle) reading a register written by an instruction accepted in cycle t with latency L can issue no earlier than cycle t+1+L. A consumer presented in cycle t+1 therefore stalls exactly L cycles.
- R2: A source with mode 2'b01 and k in 1..EARLY_MAX (needed k cycles early) can issue no earlier than cycle t+1+L+k. Values of k above EARLY_MAX are treated as EARLY_MAX.
- R3: A source with mode 2'b10 and k ≥ 1 (not read until the consumer's kth cycle) can issue at max(t+1, t+2+L−k). A value of k = 0 is treated as 1.
- R4: A load with latency 2 followed at once by a consumer that needs that register one cycle early stalls for exactly 3 cycles.
- R5: When the producer had `dst_mac` set, a source with its `src_acc` bit set needs one cycle less than the same source without the bit.
- R6: A newly accepted producer of a register replaces that register's pending countdown, whether the new latency is shorter or longer.
- R7: Register id 15 is never tracked. Writing it has no effect, and reading it never causes a stall.
- R8: An instruction of shared-unit class c accepted in cycle t with hold h stalls any later instruction of class c until cycle t+1+h. Other classes are not affected.
- R9: A synchronous reset clears every register countdown and every shared-unit window, so that no operand of any kind stalls after reset.
- R10: `stall` is low whenever `issue_valid` is low. An instruction that is presented but stalled, and then withdrawn, leaves no trace in the tracked state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_valid | input | 1 | An instruction is waiting to issue |
| src_vld | input | NSRC | Per-source valid |
| src_id | input | NSRC*IDW | Source register ids, slot s at bits [s*IDW +: IDW] |
| src_mode | input | NSRC*2 | Per-source timing: 00 first cycle, 01 early by k, 10 late until cycle k, 11 as 00 |
| src_k | input | NSRC*KW | Per-source k value |
| src_acc | input | NSRC | Source is the accumulator input of a multiply-accumulate |
| dst_vld | input | 1 | Instruction writes a register |
| dst_id | input | IDW | Destination register id |
| dst_lat | input | LAT_W | Cycles the result stays unavailable after issue |
| dst_mac | input | 1 | Result is a multiply result (one cycle shorter for accumulator readers) |
| res_vld | input | 1 | Instruction claims a shared unit |
| res_id | input | RIW | Shared-unit class |
| res_hold | input | HOLD_W | Cycles the unit stays busy after issue |
| stall | output | 1 | Instruction must not issue this cycle |

## Verification
The bench uses the default build: 16 registers, three source slots, 3-bit latencies, an early window of 2 and two shared-unit classes. With these values, every distance in the timing rules can be reached. This includes the largest latency combined with the deepest early demand, which loads a counter with 9. Two classes are enough to show that a held unit does not block a different class. The bench measures stall cycle counts for a consumer presented right after its producer. It compares each count with the formulas in the requirements.

// File: rtl/interlock_scoreboard.sv
module interlock_scoreboard #(
  parameter int NREG      = 16,
  parameter int NSRC      = 3,
  parameter int LAT_W     = 3,
  parameter int KW        = 2,
  parameter int EARLY_MAX = 2,
  parameter int NRES      = 2,
  parameter int HOLD_W    = 3,
  parameter int PC_ID     = 15,
  localparam int IDW      = $clog2(NREG),
  localparam int RIW      = (NRES > 1) ? $clog2(NRES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 issue_valid,
  input  logic [NSRC-1:0]      src_vld,
  input  logic [NSRC*IDW-1:0]  src_id,
  input  logic [NSRC*2-1:0]    src_mode,
  input  logic [NSRC*KW-1:0]   src_k,
  input  logic [NSRC-1:0]      src_acc,
  input  logic                 dst_vld,
  input  logic [IDW-1:0]       dst_id,
  input  logic [LAT_W-1:0]     dst_lat,
  input  logic                 dst_mac,
  input  logic                 res_vld,
  input  logic [RIW-1:0]       res_id,
  input  logic [HOLD_W-1:0]    res_hold,
  output logic                 stall
);
  localparam int CW = $clog2((1 << LAT_W) + EARLY_MAX);

  logic [CW-1:0]     cnt_q  [NREG];
  logic [NREG-1:0]   mac_q;
  logic [HOLD_W-1:0] busy_q [NRES];
  logic [NSRC-1:0]   src_hz;
  logic              res_hz;
  logic              fire, wr_dst;

  assign fire   = issue_valid & ~stall;
  assign wr_dst = fire & dst_vld & (int'(dst_id) != PC_ID);

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q[r] <= '0;
        mac_q[r] <= 1'b0;
      end else if (wr_dst && dst_id == IDW'(r)) begin
        cnt_q[r] <= CW'(dst_lat) + CW'(EARLY_MAX);
        mac_q[r] <= dst_mac;
      end else if (cnt_q[r] != '0) begin
        cnt_q[r] <= cnt_q[r] - 1'b1;
      end
    end

    assert_countdown_R1: assert property (@(posedge clk) disable iff (rst)
      (cnt_q[r] != '0 && !(wr_dst && dst_id == IDW'(r))) |=> cnt_q[r] == $past(cnt_q[r]) - 1'b1);
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [IDW-1:0] id;
    logic [1:0]     md;
    logic [KW-1:0]  kk;
    int             thr;
    always_comb begin
      id  = src_id[s*IDW +: IDW];
      md  = src_mode[s*2 +: 2];
      kk  = src_k[s*KW +: KW];
      thr = EARLY_MAX;
      case (md)
        2'b01:   thr = EARLY_MAX - ((int'(kk) > EARLY_MAX) ? EARLY_MAX : int'(kk));
        2'b10:   thr = EARLY_MAX + ((kk == '0) ? 0 : int'(kk) - 1);
        default: thr = EARLY_MAX;
      endcase
      if (src_acc[s] && mac_q[id]) thr = thr + 1;
      src_hz[s] = src_vld[s] && (int'(id) != PC_ID) && (int'(cnt_q[id]) > thr);
    end
  end

  for (genvar c = 0; c < NRES; c++) begin : g_res
    always_ff @(posedge clk) begin
      if (rst)
        busy_q[c] <= '0;
      else if (fire && res_vld && res_id == RIW'(c))
        busy_q[c] <= res_hold;
      else if (busy_q[c] != '0)
        busy_q[c] <= busy_q[c] - 1'b1;
    end
  end

  assign res_hz = res_vld && (int'(res_id) < NRES) && (busy_q[res_id] != '0);
  assign stall  = issue_valid & ((|src_hz) | res_hz);

  assert_idle_no_stall_R10: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |-> !stall);

  assert_unit_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && res_vld && int'(res_id) < NRES && busy_q[res_id] != '0) |-> stall);

  assert_stalled_no_write_R10: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && stall && dst_vld && cnt_q[dst_id] == '0) |=> cnt_q[$past(dst_id)] == '0);

  assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
    (fire && dst_vld && int'(dst_id) != PC_ID) |=>
      cnt_q[$past(dst_id)] == CW'($past(dst_lat)) + CW'(EARLY_MAX));

  assert_pc_untracked_R7: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && src_vld == 3'b001 && int'(src_id[IDW-1:0]) == PC_ID && !res_vld) |-> !stall);
endmodule

// File: tb/interlock_scoreboard_tb.sv
module interlock_scoreboard_tb_top;
  logic clk = 0, rst = 1, issue_valid = 0;
  logic [2:0] src_vld = 0, src_acc = 0;
  logic [11:0] src_id = 0;
  logic [5:0] src_mode = 0, src_k = 0;
  logic dst_vld = 0, dst_mac = 0, res_vld = 0, stall;
  logic [3:0] dst_id = 0;
  logic [2:0] dst_lat = 0, res_hold = 0;
  logic [0:0] res_id = 0;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  interlock_scoreboard dut_i (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .src_vld(src_vld), .src_id(src_id),
    .src_mode(src_mode), .src_k(src_k), .src_acc(src_acc), .dst_vld(dst_vld), .dst_id(dst_id),
    .dst_lat(dst_lat), .dst_mac(dst_mac), .res_vld(res_vld), .res_id(res_id),
    .res_hold(res_hold), .stall(stall));

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr();
    issue_valid = 0; src_vld = 0; src_acc = 0; src_id = 0; src_mode = 0; src_k = 0;
    dst_vld = 0; dst_mac = 0; dst_id = 0; dst_lat = 0; res_vld = 0; res_id = 0; res_hold = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go(output int n);
    n = 0;
    issue_valid = 1;
    forever begin
      #1;
      if (!stall) break;
      n++;
      @(negedge clk);
    end
    @(negedge clk);
    clr();
  endtask

  task automatic produce(int id, int lat, bit mac);
    int n;
    dst_vld = 1; dst_id = 4'(id); dst_lat = 3'(lat); dst_mac = mac;
    go(n);
  endtask

  task automatic consume(int id, int mode, int k, bit acc, output int n);
    src_vld = 3'b001; src_id[3:0] = 4'(id); src_mode[1:0] = 2'(mode);
    src_k[1:0] = 2'(k); src_acc[0] = acc;
    go(n);
  endtask

  task automatic t_reset_state();
    int n;
    for (int r = 0; r < 15; r += 3) begin
      src_vld = 3'b111;
      src_id = {4'(r + 2), 4'(r + 1), 4'(r)};
      src_mode = {2'b01, 2'b01, 2'b01}; src_k = {2'd2, 2'd2, 2'd2};
      go(n);
      check("R9 reset state", n, 0);
    end
  endtask

  task automatic t_normal();
    int n;
    for (int lat = 0; lat < 8; lat += 3) begin
      produce(3, lat, 0); consume(3, 0, 0, 0, n);
      check("R1 first-cycle source", n, lat); idle(12);
    end
  endtask

  task automatic t_early();
    int n;
    produce(5, 2, 0); consume(5, 1, 1, 0, n); check("R4 load then early shift", n, 3); idle(12);
    produce(5, 1, 0); consume(5, 1, 2, 0, n); check("R2 early by 2", n, 3); idle(12);
    produce(5, 0, 0); consume(5, 1, 1, 0, n); check("R2 early by 1, lat 0", n, 1); idle(12);
    produce(5, 7, 0); consume(5, 1, 3, 0, n); check("R2 k clamped", n, 9); idle(12);
  endtask

  task automatic t_late();
    int n;
    produce(6, 3, 0); consume(6, 2, 2, 0, n); check("R3 late until cycle 2", n, 2); idle(12);
    produce(6, 1, 0); consume(6, 2, 3, 0, n); check("R3 late covers latency", n, 0); idle(12);
    produce(6, 2, 0); consume(6, 2, 0, 0, n); check("R3 k=0 as 1", n, 2); idle(12);
  endtask

  task automatic t_acc();
    int n;
    produce(7, 2, 1); consume(7, 0, 0, 1, n); check("R5 accumulator input", n, 1); idle(12);
    produce(7, 2, 1); consume(7, 0, 0, 0, n); check("R5 plain reader of mac", n, 2); idle(12);
    produce(7, 2, 0); consume(7, 0, 0, 1, n); check("R5 acc reader of non-mac", n, 2); idle(12);
  endtask

  task automatic t_overwrite();
    int n;
    produce(3, 7, 0); produce(3, 0, 0); consume(3, 0, 0, 0, n);
    check("R6 shorter overwrite", n, 0); idle(12);
    produce(3, 1, 0); produce(3, 6, 0); consume(3, 0, 0, 0, n);
    check("R6 longer overwrite", n, 6); idle(12);
  endtask

  task automatic t_pc();
    int n;
    produce(15, 7, 0); consume(15, 1, 2, 0, n); check("R7 pc source", n, 0); idle(12);
    produce(15, 7, 0); consume(0, 1, 2, 0, n); check("R7 pc write leaves r0", n, 0); idle(12);
  endtask

  task automatic t_unit();
    int n;
    res_vld = 1; res_id = 1; res_hold = 3; go(n);
    res_vld = 1; res_id = 1; go(n); check("R8 same class", n, 3); idle(12);
    res_vld = 1; res_id = 1; res_hold = 5; go(n);
    res_vld = 1; res_id = 0; go(n); check("R8 other class", n, 0); idle(12);
  endtask

  task automatic t_reset_clear();
    int n;
    produce(2, 7, 0);
    res_vld = 1; res_id = 0; res_hold = 7; go(n);
    rst = 1; @(negedge clk); rst = 0;
    consume(2, 1, 2, 0, n); check("R9 counter cleared", n, 0);
    res_vld = 1; res_id = 0; go(n); check("R9 unit cleared", n, 0); idle(12);
  endtask

  task automatic t_withdraw();
    int n;
    produce(1, 5, 0);
    src_vld = 3'b001; src_id[3:0] = 4'd1; dst_vld = 1; dst_id = 4'd4; dst_lat = 3'd7;
    issue_valid = 1; #1; check("R10 held while stalled", int'(stall), 1);
    @(negedge clk); #1; check("R10 held while stalled", int'(stall), 1);
    issue_valid = 0; #1; check("R10 no stall when idle", int'(stall), 0);
    @(negedge clk); clr();
    consume(4, 0, 0, 0, n); check("R10 withdrawn write", n, 0); idle(12);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset_state();
    t_normal();
    t_early();
    t_late();
    t_acc();
    t_overwrite();
    t_pc();
    t_unit();
    t_reset_clear();
    t_withdraw();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule